// File: doc/BRIEF.md
# Indirect Control/Status Register File

This block is the host-side register file of a network controller. The host cannot address the four 16-bit control/status registers directly. It first writes a small register-address port to choose one of them, and then reads or writes a data port that reaches the chosen register. The choice stays in force until the host rewrites it, so a driver that polls the main control register selects it once and then reads the data port repeatedly.

Register 0 is the live control word. It holds write-one command bits (initialize, start, stop, transmit demand), seven sticky event flags that the datapath raises with single-cycle strobes and that the host clears by writing ones, an interrupt enable, and derived read-only bits: error summary, interrupt pending, and transmitter/receiver running. Registers 1 to 3 carry the 24-bit initialization block address, split low and high, and three bus-mode control bits. They accept writes only while the controller is stopped. The address and the mode bits are presented on output pins for the DMA side. The interrupt line is the enable ANDed with the pending flag.

Top module: `nic_csr_bank`

## Requirements
- R1: A write with `bus_sel_addr` high loads `bus_wdata[1:0]` as the register selection. The selection holds until the next such write. While `bus_sel_addr` is high, `bus_rdata` returns the selection in bits 1:0 and zeros above. Otherwise it returns the selected register. An access with both selects high goes to the address port.
- R2: After reset the selection is 0, register 0 reads 0x0004 (stop set), registers 1 to 3 read 0, `stopped` is high, and `irq`, `cmd_init` and `cmd_tdmd` are low.
- R3: In register 0, writing 1 to bit 0 (initialize), bit 1 (start) or bit 3 (transmit demand) sets that bit, and writing 0 leaves it unchanged. Start also clears stop and sets bit 4 (transmitter on) and bit 5 (receiver on). Initialize also clears stop. `cmd_init`, `cmd_tdmd` and `stopped` follow bits 0, 3 and 2.
- R4: Writing 1 to bit 2 (stop) sets stop. In the same cycle it clears bits 0, 1, 3, 4 and 5 and all event flags, including any flag whose strobe arrives in that cycle. Stop takes priority when it is written together with start or initialize.
- R5: Strobe `evt_strobe[k]` (k = 0 init done, 1 transmit done, 2 receive done, 3 memory error, 4 missed frame, 5 SQE error, 6 babble) sets register-0 bit 8+k. Writing 1 to bit 8+k clears it, and writing 0 leaves it set. A strobe wins over a clear in the same cycle. Strobe 0 clears bit 0, and strobe 1 clears bit 3, unless the same cycle writes 1 to that bit.
- R6: Bit 15 reads as the OR of bits 11 to 14. Bit 7 reads as the OR of bit 15 and bits 8 to 10. Writes to bits 4, 5, 7 and 15 have no effect.
- R7: Bit 6 is the interrupt enable. It is loaded from `bus_wdata[6]` on every register-0 write, whether running or stopped. `irq` equals bit 6 AND bit 7.
- R8: Register 1 stores the low address word and always reads 0 in bit 0. Register 2 stores the high address byte in bits 7:0 and reads 0 in bits 15:8. `init_addr` is {register 2 bits 7:0, register 1}.
- R9: Register 3 stores bits 2:0 (bit 0 bus-master/hold control, bit 1 address-latch control, bit 2 byte swap), reads 0 above them, and drives `bus_mode`.
- R10: While stop is clear, writes to registers 1 to 3 are ignored. Reads of these registers still return the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_addr | input | 1 | Selects the register-address port |
| bus_sel_data | input | 1 | Selects the data port |
| bus_wr | input | 1 | Write strobe for the selected port |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected port |
| evt_strobe | input | 7 | Datapath event strobes, one cycle each |
| stopped | output | 1 | Controller is in the stopped state |
| cmd_init | output | 1 | Initialize command pending |
| cmd_tdmd | output | 1 | Transmit demand pending |
| irq | output | 1 | Interrupt request |
| init_addr | output | 24 | Initialization block address |
| bus_mode | output | 3 | Bus-mode control bits |

## Verification
The bench applies directed sequences first: the selection is loaded, then the data port is read several times without reselecting. The stopped and running phases tell configuration writes that are accepted from ones that must be dropped. Register 0 is driven with single strobes, with write-ones and write-zeros on each command and flag field, with a strobe and a clear on the same flag in one cycle, and with stop written together with start. These cases separate set-wins, stop-wins and no-effect behaviour. A long stretch of random accesses mixed with random strobes then exercises priority combinations that the directed part does not name. A behavioural model checks every output on every cycle.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

   localparam int unsigned CSR_W   = 16;
   localparam int unsigned SEL_W   = 2;
   localparam int unsigned EVT_N   = 7;
   localparam int unsigned EVT_LSB = 8;

   typedef enum logic [SEL_W-1:0] {
      SEL_CTL    = 2'd0,
      SEL_ADR_LO = 2'd1,
      SEL_ADR_HI = 2'd2,
      SEL_BUS    = 2'd3
   } csr_sel_e;

   // command / status positions in the control word
   localparam int unsigned B_INIT  = 0;
   localparam int unsigned B_START = 1;
   localparam int unsigned B_STOP  = 2;
   localparam int unsigned B_TDMD  = 3;
   localparam int unsigned B_TXON  = 4;
   localparam int unsigned B_RXON  = 5;
   localparam int unsigned B_IEN   = 6;
   localparam int unsigned B_PEND  = 7;
   localparam int unsigned B_ERR   = 15;

   // event strobe indices (flag bit = EVT_LSB + index)
   localparam int unsigned EV_IDONE = 0;
   localparam int unsigned EV_TX    = 1;
   localparam int unsigned EV_RX    = 2;
   localparam int unsigned EV_MEM   = 3;

endpackage

// File: rtl/nic_csr_sel.sv
module nic_csr_sel #(
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SEL_W-1:0] din,
   output logic [SEL_W-1:0] sel_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (load) begin
         sel_q <= din;
      end
   end

endmodule

// File: rtl/nic_csr_ctl.sv
module nic_csr_ctl
   import nic_csr_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned EVT_N  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [3:0]        wr_cmd,
   input  logic              wr_ien,
   input  logic [EVT_N-1:0]  wr_clr,
   input  logic [EVT_N-1:0]  evt,
   output logic [DATA_W-1:0] word,
   output logic              stopped,
   output logic              cmd_init,
   output logic              cmd_tdmd,
   output logic              irq
);

   logic             init_q, start_q, stop_q, tdmd_q;
   logic             txon_q, rxon_q, ien_q;
   logic [EVT_N-1:0] flag_q;
   logic             stop_w, start_w, init_w, tdmd_w;
   logic             err_sum, pend;

   assign stop_w  = wr & wr_cmd[B_STOP];
   assign start_w = wr & wr_cmd[B_START];
   assign init_w  = wr & wr_cmd[B_INIT];
   assign tdmd_w  = wr & wr_cmd[B_TDMD];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q  <= 1'b0;
         start_q <= 1'b0;
         stop_q  <= 1'b1;
         tdmd_q  <= 1'b0;
         txon_q  <= 1'b0;
         rxon_q  <= 1'b0;
      end else if (stop_w) begin
         init_q  <= 1'b0;
         start_q <= 1'b0;
         stop_q  <= 1'b1;
         tdmd_q  <= 1'b0;
         txon_q  <= 1'b0;
         rxon_q  <= 1'b0;
      end else begin
         if (start_w) begin
            start_q <= 1'b1;
            stop_q  <= 1'b0;
            txon_q  <= 1'b1;
            rxon_q  <= 1'b1;
         end
         if (init_w) begin
            init_q <= 1'b1;
            stop_q <= 1'b0;
         end else if (evt[EV_IDONE]) begin
            init_q <= 1'b0;
         end
         if (tdmd_w) begin
            tdmd_q <= 1'b1;
         end else if (evt[EV_TX]) begin
            tdmd_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q <= 1'b0;
      end else if (wr) begin
         ien_q <= wr_ien;
      end
   end

   // one sticky flag per event source
   for (genvar k = 0; k < EVT_N; k++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q[k] <= 1'b0;
         end else if (stop_w) begin
            flag_q[k] <= 1'b0;
         end else if (evt[k]) begin
            flag_q[k] <= 1'b1;
         end else if (wr && wr_clr[k]) begin
            flag_q[k] <= 1'b0;
         end
      end
   end

   assign err_sum = |flag_q[EVT_N-1:EV_MEM];
   assign pend    = err_sum | (|flag_q[EV_MEM-1:0]);

   always_comb begin
      word                    = '0;
      word[B_INIT]            = init_q;
      word[B_START]           = start_q;
      word[B_STOP]            = stop_q;
      word[B_TDMD]            = tdmd_q;
      word[B_TXON]            = txon_q;
      word[B_RXON]            = rxon_q;
      word[B_IEN]             = ien_q;
      word[B_PEND]            = pend;
      word[EVT_LSB +: EVT_N]  = flag_q;
      word[B_ERR]             = err_sum;
   end

   assign stopped  = stop_q;
   assign cmd_init = init_q;
   assign cmd_tdmd = tdmd_q;
   assign irq      = ien_q & pend;

endmodule

// File: rtl/nic_csr_cfg.sv
module nic_csr_cfg
   import nic_csr_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned HI_W   = 8,
   parameter int unsigned MODE_W = 3,
   localparam int unsigned ADDR_W = DATA_W + HI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              allow,
   input  logic [1:0]        sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] lo_word,
   output logic [DATA_W-1:0] hi_word,
   output logic [DATA_W-1:0] bus_word,
   output logic [ADDR_W-1:0] init_addr,
   output logic [MODE_W-1:0] bus_mode
);

   logic [DATA_W-1:1] lo_q;
   logic [HI_W-1:0]   hi_q;
   logic [MODE_W-1:0] mode_q;
   logic              wr_ok;

   assign wr_ok = wr & allow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         mode_q <= '0;
      end else if (wr_ok) begin
         case (csr_sel_e'(sel))
            SEL_ADR_LO: lo_q   <= wdata[DATA_W-1:1];
            SEL_ADR_HI: hi_q   <= wdata[HI_W-1:0];
            SEL_BUS:    mode_q <= wdata[MODE_W-1:0];
            default:    ;
         endcase
      end
   end

   assign lo_word   = {lo_q, 1'b0};
   assign hi_word   = {{(DATA_W-HI_W){1'b0}}, hi_q};
   assign bus_word  = {{(DATA_W-MODE_W){1'b0}}, mode_q};
   assign init_addr = {hi_q, lo_q, 1'b0};
   assign bus_mode  = mode_q;

endmodule

// File: rtl/nic_csr_bank.sv
module nic_csr_bank
   import nic_csr_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned HI_W   = 8,
   parameter int unsigned MODE_W = 3,
   parameter int unsigned EVT_N  = 7,
   localparam int unsigned ADDR_W = DATA_W + HI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel_addr,
   input  logic              bus_sel_data,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [EVT_N-1:0]  evt_strobe,
   output logic              stopped,
   output logic              cmd_init,
   output logic              cmd_tdmd,
   output logic              irq,
   output logic [ADDR_W-1:0] init_addr,
   output logic [MODE_W-1:0] bus_mode
);

   // elaboration-time parameter checks
   if (DATA_W != CSR_W) begin : g_bad_width
      $error("nic_csr_bank: DATA_W must be %0d", CSR_W);
   end
   if (EVT_N != EVT_LSB - 1) begin : g_bad_evt
      $error("nic_csr_bank: EVT_N must fill bits %0d..%0d", EVT_LSB, B_ERR - 1);
   end
   if (HI_W == 0 || HI_W >= DATA_W) begin : g_bad_hi
      $error("nic_csr_bank: HI_W out of range");
   end
   if (MODE_W == 0 || MODE_W > B_TXON) begin : g_bad_mode
      $error("nic_csr_bank: MODE_W out of range");
   end

   logic              wr_addr, wr_data, wr_ctl, wr_cfg;
   logic [SEL_W-1:0]  sel_q;
   logic [DATA_W-1:0] ctl_word, lo_word, hi_word, bus_word;

   assign wr_addr = bus_wr & bus_sel_addr;
   assign wr_data = bus_wr & bus_sel_data & ~bus_sel_addr;
   assign wr_ctl  = wr_data & (sel_q == SEL_CTL);
   assign wr_cfg  = wr_data & (sel_q != SEL_CTL);

   nic_csr_sel #(.SEL_W(SEL_W)) sel_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (wr_addr),
      .din   (bus_wdata[SEL_W-1:0]),
      .sel_q (sel_q)
   );

   nic_csr_ctl #(.DATA_W(DATA_W), .EVT_N(EVT_N)) ctl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_ctl),
      .wr_cmd   (bus_wdata[B_TDMD:B_INIT]),
      .wr_ien   (bus_wdata[B_IEN]),
      .wr_clr   (bus_wdata[EVT_LSB +: EVT_N]),
      .evt      (evt_strobe),
      .word     (ctl_word),
      .stopped  (stopped),
      .cmd_init (cmd_init),
      .cmd_tdmd (cmd_tdmd),
      .irq      (irq)
   );

   nic_csr_cfg #(.DATA_W(DATA_W), .HI_W(HI_W), .MODE_W(MODE_W)) cfg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr_cfg),
      .allow     (stopped),
      .sel       (sel_q),
      .wdata     (bus_wdata),
      .lo_word   (lo_word),
      .hi_word   (hi_word),
      .bus_word  (bus_word),
      .init_addr (init_addr),
      .bus_mode  (bus_mode)
   );

   always_comb begin
      if (bus_sel_addr) begin
         bus_rdata = {{(DATA_W-SEL_W){1'b0}}, sel_q};
      end else begin
         case (csr_sel_e'(sel_q))
            SEL_CTL:    bus_rdata = ctl_word;
            SEL_ADR_LO: bus_rdata = lo_word;
            SEL_ADR_HI: bus_rdata = hi_word;
            default:    bus_rdata = bus_word;
         endcase
      end
   end

endmodule

// File: rtl/nic_csr_bank_chk.sv
module nic_csr_bank_chk #(
   parameter int unsigned SEL_W  = 2,
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned MODE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_a,
   input logic              wr_d,
   input logic [SEL_W-1:0]  wd_sel,
   input logic              wd_stop,
   input logic [SEL_W-1:0]  sel_q,
   input logic              stopped,
   input logic              cmd_init,
   input logic              cmd_tdmd,
   input logic              irq,
   input logic [ADDR_W-1:0] init_addr,
   input logic [MODE_W-1:0] bus_mode,
   input logic              rd_ctl,
   input logic              rd_err,
   input logic              rd_pend
);

   assert_sel_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_a |=> (sel_q == $past(wd_sel)));

   assert_sel_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_a |=> $stable(sel_q));

   assert_stop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_d && sel_q == '0 && wd_stop) |=> (stopped && !cmd_init && !cmd_tdmd && !irq));

   assert_err_implies_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ctl && rd_err) |-> rd_pend);

   assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(wr_d && sel_q == '0)) |=> irq);

   assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_d && sel_q != '0 && !stopped) |=> ($stable(init_addr) && $stable(bus_mode)));

endmodule

bind nic_csr_bank nic_csr_bank_chk #(
   .SEL_W  (nic_csr_pkg::SEL_W),
   .ADDR_W (DATA_W + HI_W),
   .MODE_W (MODE_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_a      (bus_wr & bus_sel_addr),
   .wr_d      (bus_wr & bus_sel_data & ~bus_sel_addr),
   .wd_sel    (bus_wdata[nic_csr_pkg::SEL_W-1:0]),
   .wd_stop   (bus_wdata[nic_csr_pkg::B_STOP]),
   .sel_q     (sel_q),
   .stopped   (stopped),
   .cmd_init  (cmd_init),
   .cmd_tdmd  (cmd_tdmd),
   .irq       (irq),
   .init_addr (init_addr),
   .bus_mode  (bus_mode),
   .rd_ctl    (~bus_sel_addr & (sel_q == '0)),
   .rd_err    (bus_rdata[nic_csr_pkg::B_ERR]),
   .rd_pend   (bus_rdata[nic_csr_pkg::B_PEND])
);

// File: tb/nic_csr_bank_tb_top.sv
`timescale 1ns/1ps
module nic_csr_bank_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel_addr = 1'b0;
   logic        bus_sel_data = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [6:0]  evt_strobe = '0;
   logic        stopped, cmd_init, cmd_tdmd, irq;
   logic [23:0] init_addr;
   logic [2:0]  bus_mode;

   int    checks = 0;
   int    failures = 0;
   string cur_req = "R2";
   bit    done = 1'b0;

   always #2.5 clk = ~clk;

   nic_csr_bank dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_sel_addr (bus_sel_addr),
      .bus_sel_data (bus_sel_data),
      .bus_wr       (bus_wr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .evt_strobe   (evt_strobe),
      .stopped      (stopped),
      .cmd_init     (cmd_init),
      .cmd_tdmd     (cmd_tdmd),
      .irq          (irq),
      .init_addr    (init_addr),
      .bus_mode     (bus_mode)
   );

   // ---------------- behavioural reference model ----------------
   bit [1:0]  m_sel;
   bit        m_init, m_start, m_stop, m_tdmd, m_txon, m_rxon, m_ien;
   bit [6:0]  m_flg;
   bit [15:0] m_lo;
   bit [7:0]  m_hi;
   bit [2:0]  m_mode;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sel = 0; m_init = 0; m_start = 0; m_stop = 1; m_tdmd = 0;
         m_txon = 0; m_rxon = 0; m_ien = 0; m_flg = 0;
         m_lo = 0; m_hi = 0; m_mode = 0;
      end else begin
         bit w0, wd;
         wd = bus_wr && bus_sel_data && !bus_sel_addr;
         w0 = wd && (m_sel == 0);
         if (wd && m_sel != 0 && m_stop) begin
            if (m_sel == 1) m_lo = bus_wdata & 16'hFFFE;
            else if (m_sel == 2) m_hi = bus_wdata[7:0];
            else m_mode = bus_wdata[2:0];
         end
         if (w0 && bus_wdata[2]) begin
            m_stop = 1; m_init = 0; m_start = 0; m_tdmd = 0;
            m_txon = 0; m_rxon = 0; m_flg = 0;
         end else begin
            if (w0 && bus_wdata[1]) begin
               m_start = 1; m_stop = 0; m_txon = 1; m_rxon = 1;
            end
            if (w0 && bus_wdata[0]) begin
               m_init = 1; m_stop = 0;
            end else if (evt_strobe[0]) m_init = 0;
            if (w0 && bus_wdata[3]) m_tdmd = 1;
            else if (evt_strobe[1]) m_tdmd = 0;
            for (int k = 0; k < 7; k++) begin
               if (evt_strobe[k]) m_flg[k] = 1;
               else if (w0 && bus_wdata[8+k]) m_flg[k] = 0;
            end
         end
         if (w0) m_ien = bus_wdata[6];
         if (bus_wr && bus_sel_addr) m_sel = bus_wdata[1:0];
      end
   end

   function automatic logic [15:0] model_rdata();
      bit err, pend;
      err  = |m_flg[6:3];
      pend = err | (|m_flg[2:0]);
      if (bus_sel_addr) return {14'b0, m_sel};
      case (m_sel)
         2'd0: return {err, m_flg, pend, m_ien, m_rxon, m_txon, m_tdmd, m_stop, m_start, m_init};
         2'd1: return m_lo;
         2'd2: return {8'h00, m_hi};
         default: return {13'b0, m_mode};
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         bit pend;
         pend = |m_flg;
         check(cur_req, "rdata", bus_rdata, model_rdata());
         check(cur_req, "irq R7", irq, m_ien & pend);
         check(cur_req, "stopped", stopped, m_stop);
         check(cur_req, "cmd_init", cmd_init, m_init);
         check(cur_req, "cmd_tdmd", cmd_tdmd, m_tdmd);
         check(cur_req, "init_addr R8", init_addr, {m_hi, m_lo});
         check(cur_req, "bus_mode R9", bus_mode, m_mode);
      end
   end

   // ---------------- stimulus helpers (called at posedge + 1ns) ----------------
   task automatic idle();
      bus_sel_addr = 0; bus_sel_data = 0; bus_wr = 0; bus_wdata = '0; evt_strobe = '0;
   endtask

   task automatic sel_reg(input logic [1:0] a);
      bus_sel_addr = 1; bus_wr = 1; bus_wdata = {14'b0, a};
      @(posedge clk); #1; idle();
   endtask

   task automatic wr_dat(input logic [15:0] d, input logic [6:0] ev);
      bus_sel_data = 1; bus_wr = 1; bus_wdata = d; evt_strobe = ev;
      @(posedge clk); #1; idle();
   endtask

   task automatic pulse(input logic [6:0] ev);
      evt_strobe = ev;
      @(posedge clk); #1; idle();
   endtask

   task automatic peek(input bit addr_port, input string req, input logic [15:0] exp);
      bus_sel_addr = addr_port; bus_sel_data = !addr_port;
      #0.5;
      check(req, "directed read", bus_rdata, exp);
      idle();
   endtask

   task automatic finish_up();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired in %s", cur_req);
      finish_up();
   end

   initial begin
      idle();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R2: reset state
      cur_req = "R2";
      peek(0, "R2", 16'h0004);
      peek(1, "R2", 16'h0000);
      check("R2", "stopped", stopped, 1'b1);
      check("R2", "irq", irq, 1'b0);
      sel_reg(1); peek(0, "R2", 16'h0000);
      sel_reg(2); peek(0, "R2", 16'h0000);
      sel_reg(3); peek(0, "R2", 16'h0000);

      // R1: persistent selection, address port readback
      cur_req = "R1";
      wr_dat(16'h0005, 7'h00);
      peek(0, "R1", 16'h0005);
      @(posedge clk); #1;
      peek(0, "R1", 16'h0005);
      peek(1, "R1", 16'h0003);

      // R8: address registers while stopped
      cur_req = "R8";
      sel_reg(1); wr_dat(16'h1235, 7'h00); peek(0, "R8", 16'h1234);
      sel_reg(2); wr_dat(16'hABCD, 7'h00); peek(0, "R8", 16'h00CD);
      check("R8", "init_addr", init_addr, 24'hCD1234);

      // R9: bus-mode register
      cur_req = "R9";
      sel_reg(3); wr_dat(16'hFFFF, 7'h00); peek(0, "R9", 16'h0007);
      check("R9", "bus_mode", bus_mode, 3'h7);

      // R3: set-on-write-one commands
      cur_req = "R3";
      sel_reg(0);
      wr_dat(16'h0000, 7'h00); peek(0, "R3", 16'h0004);
      wr_dat(16'h0001, 7'h00); peek(0, "R3", 16'h0001);
      check("R3", "stopped", stopped, 1'b0);
      wr_dat(16'h0002, 7'h00); peek(0, "R3", 16'h0033);
      wr_dat(16'h0008, 7'h00); peek(0, "R3", 16'h003B);
      check("R3", "cmd_tdmd", cmd_tdmd, 1'b1);

      // R10: configuration locked while running
      cur_req = "R10";
      sel_reg(1); wr_dat(16'h5550, 7'h00); peek(0, "R10", 16'h1234);
      sel_reg(3); wr_dat(16'h0000, 7'h00); peek(0, "R10", 16'h0007);
      sel_reg(0);

      // R5: event flags
      cur_req = "R5";
      pulse(7'h01); peek(0, "R5", 16'h01BA);
      pulse(7'h02); peek(0, "R5", 16'h03B2);
      wr_dat(16'h0100, 7'h00); peek(0, "R5", 16'h02B2);
      wr_dat(16'h0200, 7'h02); peek(0, "R5", 16'h02B2);
      wr_dat(16'h0200, 7'h00); peek(0, "R5", 16'h0032);

      // R6: error summary and read-only bits
      cur_req = "R6";
      pulse(7'h08); peek(0, "R6", 16'h88B2);
      wr_dat(16'h80B0, 7'h00); peek(0, "R6", 16'h88B2);
      wr_dat(16'h0800, 7'h00); peek(0, "R6", 16'h0032);
      pulse(7'h40); peek(0, "R6", 16'hC0B2);
      pulse(7'h04); peek(0, "R6", 16'hC4B2);

      // R7: interrupt enable and output
      cur_req = "R7";
      check("R7", "irq off", irq, 1'b0);
      wr_dat(16'h0040, 7'h00); peek(0, "R7", 16'hC4F2);
      check("R7", "irq on", irq, 1'b1);
      wr_dat(16'h4040, 7'h00); peek(0, "R7", 16'h04F2);
      check("R7", "irq held", irq, 1'b1);
      wr_dat(16'h0440, 7'h00); peek(0, "R7", 16'h0072);
      check("R7", "irq idle", irq, 1'b0);

      // R4: stop wins over start and clears everything
      cur_req = "R4";
      pulse(7'h10);
      wr_dat(16'h0046, 7'h20); peek(0, "R4", 16'h0044);
      check("R4", "irq", irq, 1'b0);
      check("R4", "stopped", stopped, 1'b1);

      // random mixed traffic, compared every cycle against the model
      cur_req = "R5_rand";
      for (int i = 0; i < 2000; i++) begin
         int unsigned r;
         r = $urandom;
         bus_sel_addr = (r[3:0] == 0);
         bus_sel_data = r[4];
         bus_wr       = r[5];
         bus_wdata    = $urandom;
         if (r[9:6] != 0) bus_wdata[2] = 1'b0;
         evt_strobe   = (r[12:10] == 0) ? 7'($urandom) : 7'h00;
         @(posedge clk); #1;
      end
      idle();
      @(posedge clk); #1;
      @(negedge clk);
      finish_up();
   end

endmodule